// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit timer whose count clock is one of four clock-enable inputs, passed through a divider of 1, 2, 4 or 8. The timer can be held, run freely with overflow, run up to a period taken from channel 0, or run up and back down using that same period. Software reads and loads the count through a small register port.

Three channels sit on the count. A channel in capture mode copies the count into its register on the chosen edge of its chosen input. That input can be a pin, a second pin, or a fixed level that software sets. A channel in compare mode raises its flag and drives its output (set, reset or toggle) when the count steps onto the channel's register value. All inputs are single-cycle enables or levels in the `clk_i` domain.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the count, the control word, every channel register and control word, the overflow flag, all channel flags and all channel outputs are 0.
- R2: Control bits [1:0] pick the count source: 0 `tclk_en_i`, 1 `aclk_en_i`, 2 `smclk_en_i`, 3 `iclk_en_i`. Pulses on the sources that are not selected do not move the count.
- R3: Control bits [3:2] set the divider to 1, 2, 4 or 8 for codes 0 to 3. One step is taken per that many selected pulses. A write to the control word restarts the divider.
- R4: Control bits [5:4] pick the mode: 0 stop, 1 up, 2 continuous, 3 up/down. In stop mode the count holds. A write to address 1 loads the count, and the load wins over a step in the same cycle.
- R5: In continuous mode the count steps from 0xFFFF to 0 and sets the overflow flag. The flag is read at bit 6 of address 0 and drives `tovf_o`. Writing bit 6 of the control word replaces the flag.
- R6: In up mode the count rises to the channel 0 register value, then goes to 0 on the next step. The wrap to 0 sets the overflow flag.
- R7: In up/down mode the count rises to the channel 0 register value and falls back to 0. Reaching 0 on the way down sets the overflow flag.
- R8: The channel control words are at addresses 2 to 4 and the channel registers at addresses 5 to 7. Bit 0 selects capture (1). Bits [2:1] select the capture edges: 0 none, 1 rising, 2 falling, 3 both. A capture copies the count into the channel register and sets the flag (bit 7, also `ccf_o`).
- R9: Control bits [4:3] select the capture input: 0 `cap_a_i`, 1 the second input, 2 a constant 0, 3 a constant 1. The second input is `cap_b_i` for channels 0 and 1, and `aclk_en_i` for channel 2. Moving from code 2 to code 3 gives a rising edge one cycle after the write.
- R10: A capture while the channel flag is already set sets the channel overflow bit (bit 8).
- R11: In compare mode, a step that brings the count to the channel register value sets the flag and applies control bits [6:5] to the output: 0 set, 1 reset, 2 toggle, 3 hold. Bit 9 reads the output and a write loads it.
- R12: When a hardware event (capture, compare match or timer overflow) and a software write of a 0 to the same flag fall in one cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tclk_en_i | input | 1 | Source 0 clock enable |
| aclk_en_i | input | 1 | Source 1 clock enable; also channel 2 second capture input |
| smclk_en_i | input | 1 | Source 2 clock enable |
| iclk_en_i | input | 1 | Source 3 clock enable |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for `bus_addr_i` (combinational) |
| cap_a_i | input | 3 | First capture input per channel |
| cap_b_i | input | 2 | Second capture input, channels 0 and 1 |
| cmp_out_o | output | 3 | Channel outputs |
| ccf_o | output | 3 | Channel flags |
| tovf_o | output | 1 | Timer overflow flag |

## Verification
A capture edge and a software write that clears the same channel's flag can land on one clock edge. The bench drives the write strobe and the rising capture input on the same cycle. It then checks that the flag stays set and that the register holds the count present at that edge. The captured-overflow bit is also checked, and it stays clear because the flag was clear before that edge. Compare matches and the counter wrap are judged by stepping the source a counted number of times and reading the count, the flags and the outputs afterwards.

// File: rtl/capcmp_timer_pkg.sv
package capcmp_timer_pkg;
  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_UP   = 2'd1,
    MODE_CONT = 2'd2,
    MODE_UPDN = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ACT_SET    = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_TOGGLE = 2'd2,
    ACT_HOLD   = 2'd3
  } out_act_e;

  // channel config, bit 0 = cap_mode
  typedef struct packed {
    out_act_e   act;
    logic [1:0] in_sel;
    logic [1:0] edge_sel;
    logic       cap_mode;
  } ch_cfg_t;

  localparam int unsigned CH_CFG_W  = 7;
  localparam int unsigned CH_STAT_W = 10;
  localparam int unsigned N_SRC     = 4;
endpackage

// File: rtl/tmr_clk_div.sv
module tmr_clk_div
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [1:0]       sel_i,
  input  logic [1:0]       div_i,
  input  logic             clr_i,
  output logic             tick_o
);
  logic             src_pulse;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  assign src_pulse = src_en_i[sel_i];

  always_comb begin
    lim = '0;
    for (int k = 0; k < DIV_W; k++) lim[k] = (k < int'(div_i));
  end

  assign tick_o = src_pulse && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (src_pulse) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  p_div_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_pulse && !clr_i) |=> $stable(cnt_q));
  p_div_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $stable(div_i)) |=> (cnt_q <= lim));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  tmr_mode_e mode_i,
  input  logic [W-1:0] period_i,
  input  logic      ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic      ovf_we_i,
  input  logic      ovf_wval_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o,
  output logic      upd_o,
  output logic      ovf_o
);
  logic [W-1:0] cnt_q, nxt;
  logic         down_q, down_nxt, wrap;

  always_comb begin
    nxt      = cnt_q;
    down_nxt = down_q;
    wrap     = 1'b0;
    unique case (mode_i)
      MODE_UP: begin
        if (cnt_q >= period_i) begin
          nxt  = '0;
          wrap = 1'b1;
        end else begin
          nxt = cnt_q + 1'b1;
        end
      end
      MODE_CONT: begin
        nxt  = cnt_q + 1'b1;
        wrap = (cnt_q == '1);
      end
      MODE_UPDN: begin
        if (!down_q && cnt_q < period_i) begin
          nxt = cnt_q + 1'b1;
        end else if (cnt_q == '0) begin
          down_nxt = 1'b0;
        end else begin
          nxt      = cnt_q - 1'b1;
          down_nxt = 1'b1;
          if (cnt_q == W'(1)) begin
            wrap     = 1'b1;
            down_nxt = 1'b0;
          end
        end
      end
      default: ;
    endcase
  end

  assign upd_o     = tick_i && (mode_i != MODE_STOP) && !ld_i;
  assign cnt_nxt_o = nxt;
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
      ovf_o  <= 1'b0;
    end else begin
      if (ld_i) begin
        cnt_q  <= ld_val_i;
        down_q <= 1'b0;
      end else if (upd_o) begin
        cnt_q  <= nxt;
        down_q <= down_nxt;
      end
      // hardware set wins over software write
      ovf_o <= (ovf_we_i ? ovf_wval_i : ovf_o) | (upd_o && wrap);
    end
  end

  p_stop_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STOP && !ld_i) |=> $stable(cnt_o));
  p_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_val_i)));
  p_cont_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_CONT && upd_o && cnt_o == '1) |=> (cnt_o == '0 && ovf_o));
  p_up_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UP && !ld_i && cnt_o <= period_i) |=> (cnt_o <= $past(period_i)));
  p_updn_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_UPDN && !ld_i && cnt_o <= period_i) |=> (cnt_o <= $past(period_i)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CH_STAT_W-1:0] cfg_wdata_i,
  input  logic                 ccr_we_i,
  input  logic [W-1:0]         ccr_wdata_i,
  input  logic [W-1:0]         cnt_i,
  input  logic [W-1:0]         cnt_nxt_i,
  input  logic                 upd_i,
  input  logic                 in_a_i,
  input  logic                 in_b_i,
  output logic [W-1:0]         ccr_o,
  output logic [CH_STAT_W-1:0] stat_o,
  output logic                 flag_o,
  output logic                 out_o
);
  ch_cfg_t cfg_q;
  logic    lvl, lvl_q, rise, fall, cap_ev, cmp_ev, cov_q;

  always_comb begin
    unique case (cfg_q.in_sel)
      2'd0:    lvl = in_a_i;
      2'd1:    lvl = in_b_i;
      2'd2:    lvl = 1'b0;
      default: lvl = 1'b1;
    endcase
  end

  assign rise   = lvl && !lvl_q;
  assign fall   = !lvl && lvl_q;
  assign cap_ev = cfg_q.cap_mode &&
                  ((cfg_q.edge_sel[0] && rise) || (cfg_q.edge_sel[1] && fall));
  assign cmp_ev = !cfg_q.cap_mode && upd_i && (cnt_nxt_i == ccr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      lvl_q  <= 1'b0;
      ccr_o  <= '0;
      flag_o <= 1'b0;
      cov_q  <= 1'b0;
      out_o  <= 1'b0;
    end else begin
      lvl_q <= lvl;
      if (cfg_we_i) cfg_q <= ch_cfg_t'(cfg_wdata_i[CH_CFG_W-1:0]);
      if (cap_ev)        ccr_o <= cnt_i;
      else if (ccr_we_i) ccr_o <= ccr_wdata_i;
      flag_o <= (cfg_we_i ? cfg_wdata_i[7] : flag_o) | cap_ev | cmp_ev;
      cov_q  <= (cfg_we_i ? cfg_wdata_i[8] : cov_q) | (cap_ev && flag_o);
      if (cmp_ev) begin
        unique case (cfg_q.act)
          ACT_SET:    out_o <= 1'b1;
          ACT_RESET:  out_o <= 1'b0;
          ACT_TOGGLE: out_o <= !out_o;
          default:    ;
        endcase
      end else if (cfg_we_i) begin
        out_o <= cfg_wdata_i[9];
      end
    end
  end

  assign stat_o = {out_o, cov_q, flag_o, cfg_q};

  p_cap_val_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ev |=> (ccr_o == $past(cnt_i)));
  p_cap_ovf_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_ev && flag_o) |=> stat_o[8]);
  p_toggle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_ev && cfg_q.act == ACT_TOGGLE) |=> (out_o != $past(out_o)));
  p_hw_flag_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_ev || cmp_ev) |=> flag_o);
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_timer_pkg::*;
#(
  parameter int unsigned W    = 16,
  parameter int unsigned N_CH = 3,
  parameter int unsigned AW   = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tclk_en_i,
  input  logic            aclk_en_i,
  input  logic            smclk_en_i,
  input  logic            iclk_en_i,
  input  logic            bus_we_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [W-1:0]    bus_wdata_i,
  output logic [W-1:0]    bus_rdata_o,
  input  logic [N_CH-1:0] cap_a_i,
  input  logic [N_CH-2:0] cap_b_i,
  output logic [N_CH-1:0] cmp_out_o,
  output logic [N_CH-1:0] ccf_o,
  output logic            tovf_o
);
  localparam int unsigned CTRL_W   = 6;
  localparam int unsigned CFG_BASE = 2;
  localparam int unsigned CCR_BASE = CFG_BASE + N_CH;

  logic [CTRL_W-1:0]    ctrl_q;
  logic                 ctrl_we, cnt_we, tick, upd;
  logic [W-1:0]         cnt, cnt_nxt;
  logic [W-1:0]         ccr [N_CH];
  logic [CH_STAT_W-1:0] stat [N_CH];

  assign ctrl_we = bus_we_i && (bus_addr_i == AW'(0));
  assign cnt_we  = bus_we_i && (bus_addr_i == AW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= bus_wdata_i[CTRL_W-1:0];
  end

  tmr_clk_div u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .src_en_i({iclk_en_i, smclk_en_i, aclk_en_i, tclk_en_i}),
    .sel_i   (ctrl_q[1:0]),
    .div_i   (ctrl_q[3:2]),
    .clr_i   (ctrl_we),
    .tick_o  (tick)
  );

  tmr_counter #(.W(W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .mode_i    (tmr_mode_e'(ctrl_q[5:4])),
    .period_i  (ccr[0]),
    .ld_i      (cnt_we),
    .ld_val_i  (bus_wdata_i),
    .ovf_we_i  (ctrl_we),
    .ovf_wval_i(bus_wdata_i[CTRL_W]),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .upd_o     (upd),
    .ovf_o     (tovf_o)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic in_b;
    if (i == N_CH - 1) begin : g_alt
      assign in_b = aclk_en_i;
    end else begin : g_pin
      assign in_b = cap_b_i[i];
    end

    tmr_channel #(.W(W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cfg_we_i   (bus_we_i && (bus_addr_i == AW'(CFG_BASE + i))),
      .cfg_wdata_i(bus_wdata_i[CH_STAT_W-1:0]),
      .ccr_we_i   (bus_we_i && (bus_addr_i == AW'(CCR_BASE + i))),
      .ccr_wdata_i(bus_wdata_i),
      .cnt_i      (cnt),
      .cnt_nxt_i  (cnt_nxt),
      .upd_i      (upd),
      .in_a_i     (cap_a_i[i]),
      .in_b_i     (in_b),
      .ccr_o      (ccr[i]),
      .stat_o     (stat[i]),
      .flag_o     (ccf_o[i]),
      .out_o      (cmp_out_o[i])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == AW'(0)) bus_rdata_o = {{(W-CTRL_W-1){1'b0}}, tovf_o, ctrl_q};
    if (bus_addr_i == AW'(1)) bus_rdata_o = cnt;
    for (int i = 0; i < int'(N_CH); i++) begin
      if (int'(bus_addr_i) == int'(CFG_BASE) + i) bus_rdata_o = {{(W-CH_STAT_W){1'b0}}, stat[i]};
      if (int'(bus_addr_i) == int'(CCR_BASE) + i) bus_rdata_o = ccr[i];
    end
  end

  p_mode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we |=> (ctrl_q == $past(bus_wdata_i[CTRL_W-1:0])));
endmodule

// File: tb/tb_capcmp_timer.sv
module tb_capcmp_timer;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tclk_en = 0, aclk_en = 0, smclk_en = 0, iclk_en = 0;
  logic        we = 0;
  logic [2:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic [2:0]  cap_a = 0;
  logic [1:0]  cap_b = 0;
  logic [2:0]  cmp_out, ccf;
  logic        tovf;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  capcmp_timer dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .tclk_en_i(tclk_en), .aclk_en_i(aclk_en), .smclk_en_i(smclk_en), .iclk_en_i(iclk_en),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .cap_a_i(cap_a), .cap_b_i(cap_b), .cmp_out_o(cmp_out), .ccf_o(ccf), .tovf_o(tovf)
  );

  // {mode, period, steps, expected count, expected overflow}
  localparam logic [42:0] VEC [9] = '{
    {2'd1, 16'd4, 8'd3, 16'd3, 1'b0},
    {2'd1, 16'd4, 8'd5, 16'd0, 1'b1},
    {2'd1, 16'd4, 8'd7, 16'd2, 1'b1},
    {2'd3, 16'd3, 8'd3, 16'd3, 1'b0},
    {2'd3, 16'd3, 8'd5, 16'd1, 1'b0},
    {2'd3, 16'd3, 8'd6, 16'd0, 1'b1},
    {2'd3, 16'd3, 8'd7, 16'd1, 1'b1},
    {2'd2, 16'd4, 8'd5, 16'd5, 1'b0},
    {2'd0, 16'd4, 8'd5, 16'd0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic step_sm(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); smclk_en = 1;
      @(negedge clk); smclk_en = 0;
    end
  endtask

  task automatic pulse_src(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      case (s) 0: tclk_en = 1; 1: aclk_en = 1; 2: smclk_en = 1; default: iclk_en = 1; endcase
      @(negedge clk); {tclk_en, aclk_en, smclk_en, iclk_en} = '0;
    end
  endtask

  function automatic logic [15:0] ctl(input int src, input int dv, input int md);
    return 16'((md << 4) | (dv << 2) | src);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(5, v); chk("R1 ccr0", v, 0);
    rd(3, v); chk("R1 ch1 ctl", v, 0);
    chk("R1 outputs", {cmp_out, ccf, tovf}, 0);

    // mode vectors: R4 R5 R6 R7
    for (int i = 0; i < 9; i++) begin
      wr(0, ctl(2, 0, 0));
      wr(1, 0);
      wr(5, VEC[i][40:25]);
      wr(0, ctl(2, 0, int'(VEC[i][42:41])));
      step_sm(int'(VEC[i][24:17]));
      rd(1, v); chk("R6/R7/R4 mode count", v, VEC[i][16:1]);
      rd(0, v); chk("R5/R6/R7 overflow", v[6], VEC[i][0]);
    end

    // R2 R3 source and divider
    wr(0, ctl(1, 2, 2)); wr(1, 0);
    pulse_src(1, 8);
    rd(1, v); chk("R3 div by 4", v, 2);
    pulse_src(0, 3); pulse_src(2, 3); pulse_src(3, 3);
    rd(1, v); chk("R2 unselected ignored", v, 2);
    wr(0, ctl(0, 0, 2)); pulse_src(0, 3);
    rd(1, v); chk("R2 tclk source", v, 5);
    wr(0, ctl(3, 1, 2)); pulse_src(3, 4);
    rd(1, v); chk("R3 iclk div by 2", v, 7);

    // R5 continuous wrap
    wr(0, ctl(2, 0, 2)); wr(1, 16'hFFFE);
    step_sm(2);
    rd(1, v); chk("R5 wrap count", v, 0);
    chk("R5 tovf", tovf, 1);

    // R11 compare
    wr(0, ctl(2, 0, 0)); wr(1, 0);
    wr(5, 10); wr(2, 16'h060);
    wr(6, 3);  wr(3, 16'h040);
    wr(7, 5);  wr(4, 16'h000);
    wr(0, ctl(2, 0, 1));
    step_sm(2);
    chk("R11 no match yet", {ccf[1], cmp_out[1]}, 0);
    step_sm(1);
    chk("R11 toggle on match", {ccf[1], cmp_out[1]}, 2'b11);
    step_sm(2);
    chk("R11 set on match", {ccf[2], cmp_out[2]}, 2'b11);
    step_sm(9);
    rd(1, v); chk("R6 count after wrap", v, 3);
    chk("R11 toggle back", cmp_out[1], 0);
    wr(4, 16'h220);
    step_sm(2);
    chk("R11 reset on match", cmp_out[2], 0);

    // R8 R10 capture
    wr(0, ctl(2, 0, 0)); wr(1, 16'h1234);
    wr(2, 16'h003);
    @(negedge clk); cap_a[0] = 1;
    @(negedge clk);
    rd(5, v); chk("R8 rising capture", v, 16'h1234);
    chk("R8 flag", ccf[0], 1);
    wr(1, 16'h2222);
    @(negedge clk); cap_a[0] = 0;
    @(negedge clk);
    rd(5, v); chk("R8 fall ignored in rise mode", v, 16'h1234);
    @(negedge clk); cap_a[0] = 1;
    @(negedge clk);
    rd(5, v); chk("R8 second capture", v, 16'h2222);
    rd(2, v); chk("R10 capture overflow", v[8], 1);

    // R8 edge code 0
    wr(3, 16'h009); wr(6, 16'h0055);
    @(negedge clk); cap_b[1] = 1;
    @(negedge clk); cap_b[1] = 0;
    @(negedge clk);
    rd(6, v); chk("R8 no edges selected", v, 16'h0055);
    chk("R8 no flag", ccf[1], 0);

    // R8 both edges via second input
    wr(3, 16'h00F); wr(1, 16'h0100);
    @(negedge clk); cap_b[1] = 1;
    @(negedge clk);
    rd(6, v); chk("R8 both edges rise", v, 16'h0100);
    wr(3, 16'h00F); wr(1, 16'h0200);
    @(negedge clk); cap_b[1] = 0;
    @(negedge clk);
    rd(6, v); chk("R8 both edges fall", v, 16'h0200);

    // R9 software capture
    wr(3, 16'h013); wr(1, 16'h0300);
    wr(3, 16'h01B);
    @(negedge clk);
    rd(6, v); chk("R9 software capture", v, 16'h0300);
    chk("R9 software capture flag", ccf[1], 1);

    // R9 channel 2 alternate input
    wr(4, 16'h00B); wr(1, 16'h0777);
    pulse_src(1, 1);
    rd(7, v); chk("R9 ch2 aux input capture", v, 16'h0777);

    // R12 capture and flag clear in one cycle
    @(negedge clk); cap_a[0] = 0;
    wr(2, 16'h003); wr(1, 16'h0999);
    @(negedge clk); we = 1; addr = 2; wdata = 16'h003; cap_a[0] = 1;
    @(negedge clk); we = 0;
    chk("R12 flag survives clear", ccf[0], 1);
    rd(5, v); chk("R12 captured value", v, 16'h0999);
    rd(2, v); chk("R12 no capture overflow", v[8], 0);

    finish_run();
  end
endmodule